// File: doc/BRIEF.md
# Voice Channel Register Decoder

This block is the write-side register front end of a 64-voice sample playback engine. A host issues 32-bit writes into one of two address windows. Each window covers 32 voices, and each voice owns a 128-byte slot. The block keeps only the low half-word of each write. It splits that half-word into per-voice playback parameters: a 21-bit start address, a loop flag, the sample encoding, loop start, loop end, playback rate, pan and level. The results go into per-voice register arrays, which the playback engine reads through an indexed port.

A write to a voice's control word can also produce a one-cycle key-on or key-off strobe, tagged with the voice number. The pitch word is a packed floating-point code: a direction flag, a 3-bit exponent and a 10-bit mantissa, scaled from a 44.1 kHz base. A two-stage pipeline turns it into samples per second. Pan codes are folded onto a smooth 0..31 scale, and the level index is mapped through a computed square-law curve.

Top module: `voice_reg_decoder`

## Requirements
- R1: The voice index is `wr_addr[11:7]` when `wr_win` is 0, and `wr_addr[11:7] + 32` when `wr_win` is 1; `wr_addr[6:0]` is the byte offset inside the voice slot.
- R2: Bits 31:16 of `wr_data` never affect any stored field or strobe.
- R3: A write at offset 0x00 stores data bits 4:0 as start-address bits 20:16 and data bit 9 as the loop flag, and leaves start-address bits 15:0 unchanged.
- R4: A write at offset 0x00 stores the encoding from data bits 8:7 as `rd_fmt`: 0 gives 0 (16-bit), 1 gives 1 (8-bit), 2 and 3 both give 2 (ADPCM); `rd_fmt` never reads 3.
- R5: A write at offset 0x00 with data bits 15:14 = 3 raises `key_on` for exactly the next cycle, and with 2 raises `key_off`, with `key_voice` holding the written voice; values 0 and 1 raise neither.
- R6: Offsets 0x04, 0x08 and 0x0C store data bits 15:0 as start-address bits 15:0, loop start and loop end; these and all other non-rate fields read back on `rd_*` the cycle after the write.
- R7: A write at offset 0x18 with mantissa m = bits 9:0, exponent x = bits 13:11 and flag n = bit 14 (bit 10 ignored) stores rate = (44100>>(8-x)) + ((44100*m)>>(18-x)) when n=1, else (44100<<x) + ((44100*m)>>(10-x)); the value reads back two cycles after the write.
- R8: A write at offset 0x24 takes v = data bits 4:0 and stores 15-v as pan when v is 15 or less, and v itself otherwise.
- R9: A write at offset 0x28 takes i = data bits 7:0 and stores level (i*(i+1))>>8, so the level curve runs from 0 at i=0 to 255 at i=255.
- R10: A write at any other offset (including 0x10, 0x14, 0x1C, 0x20 and offsets that are not word aligned) changes no field and raises no strobe.
- R11: After reset every field of every voice reads 0 and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_win | input | 1 | Window select: 0 for voices 0-31, 1 for voices 32-63 |
| wr_addr | input | 12 | Byte address inside the window |
| wr_data | input | 32 | Write data; only bits 15:0 are used |
| key_on | output | 1 | One-cycle key-on pulse |
| key_off | output | 1 | One-cycle key-off pulse |
| key_voice | output | 6 | Voice tagged by the last strobe |
| rd_voice | input | 6 | Voice selected for read-back |
| rd_start | output | 21 | Start address of the selected voice |
| rd_loop | output | 1 | Loop flag |
| rd_fmt | output | 2 | Sample encoding: 0 16-bit, 1 8-bit, 2 ADPCM |
| rd_loop_start | output | 16 | Loop start |
| rd_end | output | 16 | Loop end |
| rd_rate | output | 24 | Playback rate in samples per second |
| rd_pan | output | 5 | Folded pan |
| rd_vol | output | 8 | Level after the curve |

## Verification
The pitch converter is swept over both exponent directions, all eight exponents and all 1024 mantissas, with bit 10 toggled along the way. This separates errors in the base shift, in the fraction shift and in the direction flag. Pan and level are swept across all their input codes, with junk in the upper half-word. This exposes a wrong fold point, a wrong curve, or upper bits leaking into a field. The control-word sweep crosses every encoding with every key code and both loop values. A pass over all 64 voices uses distinct data in each voice, which catches a missing window offset or a slot overlap. Writes to unmapped offsets are followed by a full read-back of the voice they aimed at.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

  typedef enum logic [1:0] {
    FMT_PCM16 = 2'd0,
    FMT_PCM8  = 2'd1,
    FMT_ADPCM = 2'd2
  } smp_fmt_e;

  typedef enum logic [2:0] {
    FS_NONE,
    FS_CFG,
    FS_START_LO,
    FS_LOOP_ST,
    FS_LOOP_END,
    FS_PITCH,
    FS_PAN,
    FS_VOL
  } field_e;

  // Both ADPCM codes collapse onto one encoding.
  function automatic smp_fmt_e fmt_decode(input logic [1:0] code);
    case (code)
      2'd0:    return FMT_PCM16;
      2'd1:    return FMT_PCM8;
      default: return FMT_ADPCM;
    endcase
  endfunction

  // The lower half of the pan range is mirrored so that the scale runs smoothly.
  function automatic logic [4:0] pan_fold(input logic [4:0] v);
    return v[4] ? v : (5'd15 - v);
  endfunction

  // Square-law level curve: (i*(i+1))>>8, from 0 to 255.
  function automatic logic [7:0] vol_curve(input logic [7:0] i);
    logic [16:0] sq;
    sq = {9'd0, i} * ({9'd0, i} + 17'd1);
    return sq[15:8];
  endfunction

endpackage

// File: rtl/vrd_addr_decode.sv
module vrd_addr_decode
  import vrd_pkg::*;
#(
  parameter int WIN_VOICES = 32,
  parameter int ADDR_W     = $clog2(WIN_VOICES) + 7,
  parameter int VIDX_W     = $clog2(2 * WIN_VOICES)
) (
  input  logic              wr_en,
  input  logic              wr_win,
  input  logic [ADDR_W-1:0] wr_addr,
  output field_e            field,
  output logic [VIDX_W-1:0] voice
);

  localparam int SLOT_W = ADDR_W - 7;

  logic [SLOT_W-1:0] slot;

  assign slot = wr_addr[ADDR_W-1:7];

  always_comb begin
    if (wr_win) voice = VIDX_W'(slot) + VIDX_W'(WIN_VOICES);
    else        voice = VIDX_W'(slot);
  end

  always_comb begin
    field = FS_NONE;
    if (wr_en) begin
      case (wr_addr[6:0])
        7'h00:   field = FS_CFG;
        7'h04:   field = FS_START_LO;
        7'h08:   field = FS_LOOP_ST;
        7'h0C:   field = FS_LOOP_END;
        7'h18:   field = FS_PITCH;
        7'h24:   field = FS_PAN;
        7'h28:   field = FS_VOL;
        default: field = FS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/vrd_pitch_conv.sv
module vrd_pitch_conv #(
  parameter int VIDX_W    = 6,
  parameter int RATE_W    = 24,
  parameter int BASE_RATE = 44100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [14:0]       in_code,
  input  logic [VIDX_W-1:0] in_voice,
  output logic              out_vld,
  output logic [VIDX_W-1:0] out_voice,
  output logic [RATE_W-1:0] out_rate
);

  localparam int MANT_W = 10;
  localparam int PROD_W = RATE_W + MANT_W;
  localparam logic [RATE_W-1:0] BASE_V = RATE_W'(BASE_RATE);

  logic              neg;
  logic [2:0]        ex;
  logic [MANT_W-1:0] mant;
  logic              unused_gap;

  logic [RATE_W-1:0] base_nxt, base_q;
  logic [PROD_W-1:0] prod_nxt, prod_q;
  logic [4:0]        sh_nxt, sh_q;
  logic              vld_q;
  logic [VIDX_W-1:0] voice_q;

  assign neg        = in_code[14];
  assign ex         = in_code[13:11];
  assign mant       = in_code[MANT_W-1:0];
  assign unused_gap = in_code[10];

  // Stage 1: integer part by shifting the base, plus the raw mantissa product.
  always_comb begin
    if (neg) begin
      base_nxt = BASE_V >> (4'd8 - {1'b0, ex});
      sh_nxt   = 5'd18 - {2'b00, ex};
    end else begin
      base_nxt = BASE_V << ex;
      sh_nxt   = 5'd10 - {2'b00, ex};
    end
    prod_nxt = PROD_W'(BASE_V) * PROD_W'(mant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      voice_q <= '0;
      base_q  <= '0;
      prod_q  <= '0;
      sh_q    <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        voice_q <= in_voice;
        base_q  <= base_nxt;
        prod_q  <= prod_nxt;
        sh_q    <= sh_nxt;
      end
    end
  end

  // Stage 2: the fractional shift and the sum feed the rate array's register.
  assign out_vld   = vld_q;
  assign out_voice = voice_q;
  assign out_rate  = base_q + RATE_W'(prod_q >> sh_q);

endmodule

// File: rtl/vrd_voice_regs.sv
module vrd_voice_regs
  import vrd_pkg::*;
#(
  parameter int NUM_VOICES = 64,
  parameter int VIDX_W     = $clog2(NUM_VOICES),
  parameter int RATE_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  field_e            wr_field,
  input  logic [VIDX_W-1:0] wr_voice,
  input  logic [15:0]       wr_val,
  input  logic              rt_vld,
  input  logic [VIDX_W-1:0] rt_voice,
  input  logic [RATE_W-1:0] rt_val,
  input  logic [VIDX_W-1:0] rd_voice,
  output logic [20:0]       rd_start,
  output logic              rd_loop,
  output logic [1:0]        rd_fmt,
  output logic [15:0]       rd_loop_start,
  output logic [15:0]       rd_end,
  output logic [RATE_W-1:0] rd_rate,
  output logic [4:0]        rd_pan,
  output logic [7:0]        rd_vol
);

  logic [4:0]        start_hi_q [NUM_VOICES];
  logic [15:0]       start_lo_q [NUM_VOICES];
  logic              loop_q     [NUM_VOICES];
  smp_fmt_e          fmt_q      [NUM_VOICES];
  logic [15:0]       lstart_q   [NUM_VOICES];
  logic [15:0]       lend_q     [NUM_VOICES];
  logic [RATE_W-1:0] rate_q     [NUM_VOICES];
  logic [4:0]        pan_q      [NUM_VOICES];
  logic [7:0]        vol_q      [NUM_VOICES];

  smp_fmt_e   fmt_w;
  logic [4:0] pan_w;
  logic [7:0] vol_w;

  always_comb begin
    fmt_w = fmt_decode(wr_val[8:7]);
    pan_w = pan_fold(wr_val[4:0]);
    vol_w = vol_curve(wr_val[7:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VOICES; i++) begin
        start_hi_q[i] <= '0;
        start_lo_q[i] <= '0;
        loop_q[i]     <= 1'b0;
        fmt_q[i]      <= FMT_PCM16;
        lstart_q[i]   <= '0;
        lend_q[i]     <= '0;
        rate_q[i]     <= '0;
        pan_q[i]      <= '0;
        vol_q[i]      <= '0;
      end
    end else begin
      case (wr_field)
        FS_CFG: begin
          start_hi_q[wr_voice] <= wr_val[4:0];
          loop_q[wr_voice]     <= wr_val[9];
          fmt_q[wr_voice]      <= fmt_w;
        end
        FS_START_LO: start_lo_q[wr_voice] <= wr_val;
        FS_LOOP_ST:  lstart_q[wr_voice]   <= wr_val;
        FS_LOOP_END: lend_q[wr_voice]     <= wr_val;
        FS_PAN:      pan_q[wr_voice]      <= pan_w;
        FS_VOL:      vol_q[wr_voice]      <= vol_w;
        default: ;
      endcase
      if (rt_vld) rate_q[rt_voice] <= rt_val;
    end
  end

  always_comb begin
    rd_start      = {start_hi_q[rd_voice], start_lo_q[rd_voice]};
    rd_loop       = loop_q[rd_voice];
    rd_fmt        = fmt_q[rd_voice];
    rd_loop_start = lstart_q[rd_voice];
    rd_end        = lend_q[rd_voice];
    rd_rate       = rate_q[rd_voice];
    rd_pan        = pan_q[rd_voice];
    rd_vol        = vol_q[rd_voice];
  end

endmodule

// File: rtl/voice_reg_decoder.sv
module voice_reg_decoder
  import vrd_pkg::*;
#(
  parameter int WIN_VOICES = 32,
  parameter int RATE_W     = 24,
  parameter int BASE_RATE  = 44100,
  parameter int ADDR_W     = $clog2(WIN_VOICES) + 7,
  parameter int VIDX_W     = $clog2(2 * WIN_VOICES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_win,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              key_on,
  output logic              key_off,
  output logic [VIDX_W-1:0] key_voice,
  input  logic [VIDX_W-1:0] rd_voice,
  output logic [20:0]       rd_start,
  output logic              rd_loop,
  output logic [1:0]        rd_fmt,
  output logic [15:0]       rd_loop_start,
  output logic [15:0]       rd_end,
  output logic [RATE_W-1:0] rd_rate,
  output logic [4:0]        rd_pan,
  output logic [7:0]        rd_vol
);

  localparam int NUM_VOICES = 2 * WIN_VOICES;

  logic [1:0]        rst_q;
  logic              rst_sync_n;
  logic [15:0]       wval;
  logic              unused_hi;
  field_e            field;
  logic [VIDX_W-1:0] voice;

  logic              kon_nxt, koff_nxt, kon_q, koff_q;
  logic [VIDX_W-1:0] kvoice_nxt, kvoice_q;

  logic              rt_vld;
  logic [VIDX_W-1:0] rt_voice;
  logic [RATE_W-1:0] rt_val;

  // Reset synchronizer: asserts immediately, releases after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  assign wval      = wr_data[15:0];
  assign unused_hi = ^wr_data[31:16];

  vrd_addr_decode #(
    .WIN_VOICES (WIN_VOICES),
    .ADDR_W     (ADDR_W),
    .VIDX_W     (VIDX_W)
  ) u_dec (
    .wr_en   (wr_en),
    .wr_win  (wr_win),
    .wr_addr (wr_addr),
    .field   (field),
    .voice   (voice)
  );

  // Key strobes: next-state logic.
  always_comb begin
    kon_nxt    = (field == FS_CFG) && (wval[15:14] == 2'b11);
    koff_nxt   = (field == FS_CFG) && (wval[15:14] == 2'b10);
    kvoice_nxt = kvoice_q;
    if (kon_nxt || koff_nxt) kvoice_nxt = voice;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      kon_q    <= 1'b0;
      koff_q   <= 1'b0;
      kvoice_q <= '0;
    end else begin
      kon_q    <= kon_nxt;
      koff_q   <= koff_nxt;
      kvoice_q <= kvoice_nxt;
    end
  end

  assign key_on    = kon_q;
  assign key_off   = koff_q;
  assign key_voice = kvoice_q;

  vrd_pitch_conv #(
    .VIDX_W    (VIDX_W),
    .RATE_W    (RATE_W),
    .BASE_RATE (BASE_RATE)
  ) u_pitch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_vld    (field == FS_PITCH),
    .in_code   (wval[14:0]),
    .in_voice  (voice),
    .out_vld   (rt_vld),
    .out_voice (rt_voice),
    .out_rate  (rt_val)
  );

  vrd_voice_regs #(
    .NUM_VOICES (NUM_VOICES),
    .VIDX_W     (VIDX_W),
    .RATE_W     (RATE_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_field      (field),
    .wr_voice      (voice),
    .wr_val        (wval),
    .rt_vld        (rt_vld),
    .rt_voice      (rt_voice),
    .rt_val        (rt_val),
    .rd_voice      (rd_voice),
    .rd_start      (rd_start),
    .rd_loop       (rd_loop),
    .rd_fmt        (rd_fmt),
    .rd_loop_start (rd_loop_start),
    .rd_end        (rd_end),
    .rd_rate       (rd_rate),
    .rd_pan        (rd_pan),
    .rd_vol        (rd_vol)
  );

endmodule

// File: rtl/voice_reg_decoder_chk.sv
module voice_reg_decoder_chk #(
  parameter int ADDR_W = 12,
  parameter int VIDX_W = 6,
  parameter int RATE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_win,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              key_on,
  input logic              key_off,
  input logic [VIDX_W-1:0] key_voice,
  input logic [VIDX_W-1:0] rd_voice,
  input logic [1:0]        rd_fmt,
  input logic [RATE_W-1:0] rd_rate,
  input logic [4:0]        rd_pan,
  input logic [7:0]        rd_vol
);

  logic mapped;
  always_comb begin
    case (wr_addr[6:0])
      7'h00, 7'h04, 7'h08, 7'h0C, 7'h18, 7'h24, 7'h28: mapped = 1'b1;
      default: mapped = 1'b0;
    endcase
  end

  // R5: a key-on pulse always traces back to a control write with code 3
  a_r5_key_on_source: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |-> ($past(wr_en) && $past(wr_addr[6:0]) == 7'h00 && $past(wr_data[15:14]) == 2'b11));

  // R5: a key-off control write strobes next cycle with the voice tag (R1)
  a_r5_key_off_voice: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[6:0] == 7'h00 && wr_data[15:14] == 2'b10)
      |=> (key_off && !key_on && key_voice == VIDX_W'($past({wr_win, wr_addr[ADDR_W-1:7]}))));

  // R4: the stored encoding never reads 3
  a_r4_fmt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fmt != 2'b11);

  // R10: unmapped offsets raise no strobe
  a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> (!key_on && !key_off));

  // R6: without a write the visible fields hold
  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_voice) && !$past(wr_en)) |-> ($stable(rd_pan) && $stable(rd_vol) && $stable(rd_fmt)));

  // R7: the rate changes only two cycles after a write
  a_r7_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_voice) && !$past(wr_en, 2)) |-> $stable(rd_rate));

endmodule

bind voice_reg_decoder voice_reg_decoder_chk #(
  .ADDR_W (ADDR_W),
  .VIDX_W (VIDX_W),
  .RATE_W (RATE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_win    (wr_win),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .key_on    (key_on),
  .key_off   (key_off),
  .key_voice (key_voice),
  .rd_voice  (rd_voice),
  .rd_fmt    (rd_fmt),
  .rd_rate   (rd_rate),
  .rd_pan    (rd_pan),
  .rd_vol    (rd_vol)
);

// File: tb/voice_reg_decoder_bench.sv
module voice_reg_decoder_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_win;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;
  logic        key_on, key_off;
  logic [5:0]  key_voice;
  logic [5:0]  rd_voice;
  logic [20:0] rd_start;
  logic        rd_loop;
  logic [1:0]  rd_fmt;
  logic [15:0] rd_loop_start, rd_end;
  logic [23:0] rd_rate;
  logic [4:0]  rd_pan;
  logic [7:0]  rd_vol;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  voice_reg_decoder u_voice_reg_decoder (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_win (wr_win),
    .wr_addr (wr_addr), .wr_data (wr_data), .key_on (key_on),
    .key_off (key_off), .key_voice (key_voice), .rd_voice (rd_voice),
    .rd_start (rd_start), .rd_loop (rd_loop), .rd_fmt (rd_fmt),
    .rd_loop_start (rd_loop_start), .rd_end (rd_end), .rd_rate (rd_rate),
    .rd_pan (rd_pan), .rd_vol (rd_vol)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; return on the next falling edge.
  task automatic wr(input int voice, input logic [6:0] off, input logic [31:0] data);
    wr_en   = 1'b1;
    wr_win  = voice[5];
    wr_addr = {voice[4:0], off};
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int unsigned rate_ref(input logic [14:0] c);
    int unsigned m, x, e;
    m = c[9:0];
    x = c[13:11];
    if (c[14]) begin
      e = 8 - x;
      return (44100 >> e) + ((44100 * m) >> (10 + e));
    end
    return (44100 << x) + ((44100 * m) >> (10 - x));
  endfunction

  function automatic int unsigned vol_ref(input int unsigned i);
    return (i * (i + 1)) >> 8;
  endfunction

  function automatic int unsigned pan_ref(input int unsigned v);
    return (v < 16) ? (15 - v) : v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_win = 1'b0; wr_addr = '0; wr_data = '0; rd_voice = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check("R11 key_on", {31'd0, key_on}, 0);
    check("R11 key_off", {31'd0, key_off}, 0);
    for (int v = 0; v < 64; v += 21) begin
      rd_voice = v[5:0];
      #1;
      check("R11 start", {11'd0, rd_start}, 0);
      check("R11 rate", {8'd0, rd_rate}, 0);
      check("R11 misc", {rd_loop, rd_fmt, rd_pan, rd_vol, rd_end}, 0);
    end

    // R1, R6: a distinct value for every voice across both windows
    for (int v = 0; v < 64; v++) wr(v, 7'h04, 32'(v * 977 + 13));
    for (int v = 0; v < 64; v++) wr(v, 7'h0C, 32'(v * 331 + 5));
    for (int v = 0; v < 64; v++) begin
      rd_voice = v[5:0];
      #1;
      check("R1 start_lo per voice", {11'd0, rd_start}, 32'((v * 977 + 13) & 16'hFFFF));
      check("R6 end per voice", {16'd0, rd_end}, 32'((v * 331 + 5) & 16'hFFFF));
    end

    // R2, R6: loop start ignores the upper half-word and is visible next cycle
    rd_voice = 6'd40;
    wr(40, 7'h08, 32'hABCD_1234);
    check("R2 R6 loop start", {16'd0, rd_loop_start}, 32'h1234);

    // R3, R4, R5: control word sweep
    rd_voice = 6'd45;
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < 4; k++)
        for (int lp = 0; lp < 2; lp++) begin
          logic [15:0] d;
          d = 16'((k << 14) | (lp << 9) | (f << 7) | ((f * 4 + k + lp) & 31));
          wr(45, 7'h00, {16'hFFFF, d});
          check("R3 start hi/lo", {11'd0, rd_start},
                32'((((f * 4 + k + lp) & 31) << 16) | ((45 * 977 + 13) & 16'hFFFF)));
          check("R3 loop", {31'd0, rd_loop}, 32'(lp));
          check("R4 fmt", {30'd0, rd_fmt}, (f >= 2) ? 32'd2 : 32'(f));
          check("R5 key_on", {31'd0, key_on}, (k == 3) ? 32'd1 : 32'd0);
          check("R5 key_off", {31'd0, key_off}, (k == 2) ? 32'd1 : 32'd0);
          if (k >= 2) check("R5 key_voice", {26'd0, key_voice}, 32'd45);
          @(negedge clk);
          check("R5 pulse width", {30'd0, key_on, key_off}, 0);
        end
    wr(7, 7'h00, 32'h0000_C000);
    check("R5 voice window0", {26'd0, key_voice}, 7);

    // R8: pan fold over all codes
    rd_voice = 6'd33;
    for (int p = 0; p < 32; p++) begin
      wr(33, 7'h24, 32'(32'h5A5A_FFE0 | p));
      check("R8 pan", {27'd0, rd_pan}, pan_ref(p));
    end

    // R9: level curve over all indices
    rd_voice = 6'd2;
    for (int i = 0; i < 256; i++) begin
      wr(2, 7'h28, 32'(32'hC3C3_FF00 | i));
      check("R9 vol", {24'd0, rd_vol}, vol_ref(i));
    end

    // R7: pitch sweep over flag, exponent and mantissa
    for (int n = 0; n < 2; n++)
      for (int x = 0; x < 8; x++)
        for (int m = 0; m < 1024; m++) begin
          logic [14:0] c;
          c = 15'((n << 14) | (x << 11) | ((m & 1) << 10) | m);
          rd_voice = 6'(m);
          wr(m & 63, 7'h18, {17'h1_5555, c});
          @(negedge clk);
          check("R7 rate", {8'd0, rd_rate}, rate_ref(c));
        end

    // R10: unmapped offsets change nothing
    rd_voice = 6'd33;
    begin
      logic [20:0] s0; logic l0; logic [1:0] f0; logic [15:0] ls0, e0;
      logic [23:0] r0; logic [4:0] p0; logic [7:0] v0;
      logic [6:0] offs [6];
      offs = '{7'h10, 7'h14, 7'h1C, 7'h20, 7'h01, 7'h7C};
      #1;
      s0 = rd_start; l0 = rd_loop; f0 = rd_fmt; ls0 = rd_loop_start;
      e0 = rd_end; r0 = rd_rate; p0 = rd_pan; v0 = rd_vol;
      for (int o = 0; o < 6; o++) begin
        wr(33, offs[o], 32'hFFFF_FFFF);
        check("R10 strobes", {30'd0, key_on, key_off}, 0);
        @(negedge clk);
        check("R10 start", {11'd0, rd_start}, {11'd0, s0});
        check("R10 fields", {rd_loop, rd_fmt, rd_pan, rd_vol}, {16'd0, l0, f0, p0, v0});
        check("R10 ranges", {rd_loop_start, rd_end}, {ls0, e0});
        check("R10 rate", {8'd0, rd_rate}, {8'd0, r0});
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule